// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block decides when a DRAM memory controller has to run refresh cycles, and it supplies the row to refresh. A free-running interval counter measures time in clocks. The scheduler raises a refresh request to an existing memory state machine. The state machine answers each refresh cycle with a one-clock row strobe. Each strobe moves the refresh row pointer forward by one.

There are two policies. In spread mode, one refresh is requested per slot. The slot is the retention period divided by the number of rows, shortened by the controller's worst-case response latency shared out over all rows. In burst mode, the counter spans the whole retention period. At each boundary the row pointer is cleared to zero and the request is held through one refresh of every row, back to back. A one-clock done flag marks the end of the burst, and the rest of that period carries no requests. The mode input is adopted only at an interval boundary and never while a burst is in progress.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high, and on the first cycle after it, the request and the done flag are 0 and the row address is 0.
- R2: In spread mode the request rises once every SLOT clocks, where SLOT = PERIOD_CLKS/ROWS - ceil(LAT_CLKS/ROWS) and PERIOD_CLKS = CLK_KHZ*PERIOD_US/1000. The first rise comes SLOT clocks after reset is released.
- R3: In spread mode the request stays high until a row strobe is sampled with it. It is low from the next clock edge onward, and the row address has advanced by one at that edge (modulo ROWS).
- R4: A row strobe sampled while the request is low has no effect, and the row address keeps its value.
- R5: The interval counter reloads at once at its terminal count, so the instants at which requests rise do not depend on how many clocks the controller takes to answer.
- R6: A burst starts at the interval boundary after burst mode (mode input = 1) is selected. At that edge the row address is cleared to 0 and the request rises.
- R7: During a burst the request stays high through exactly ROWS strobes, and the row advances on each one. It falls at the edge where the row returns to 0, and the done flag is high for exactly that one following cycle.
- R8: In burst mode the interval is PERIOD_CLKS clocks. After a burst has finished, no request rises before the next boundary.
- R9: A change of the mode input takes effect only at an interval boundary. A burst in progress is not cut short by the change, and the interval length in force is not altered by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_mode_i | input | 1 | 1 selects burst refresh, 0 selects spread refresh |
| row_strobe_i | input | 1 | One-clock pulse from the memory controller for each refresh cycle it runs |
| refresh_req_o | output | 1 | Refresh request to the memory controller |
| refresh_row_o | output | ROW_W | Row address to refresh |
| burst_done_o | output | 1 | One-clock pulse when a burst has covered all rows |

## Verification
In spread mode the bench uses a range of service delays, from an immediate strobe up to one that arrives most of the way through the slot. This separates a counter that reloads on its own from one that waits for service: with a waiting counter, the rise times would drift as the delays change. A stray strobe sent before the first request checks that unrequested strobes leave the row alone. The bench then switches to burst mode with a non-zero row pending, so the clear at burst start can be seen. It flips the mode back during the burst, which tells apart a design that defers the change from one that aborts the burst or shortens the running interval. The first post-burst request must fall exactly one full period after the burst began.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    typedef enum logic {
        MODE_SPREAD = 1'b0,
        MODE_BURST  = 1'b1
    } refresh_mode_e;

    function automatic int period_clocks(input int clk_khz, input int period_us);
        return (clk_khz * period_us) / 1000;
    endfunction

    // spread-mode slot: period share per row minus the latency spread over all rows
    function automatic int spread_slot(input int period, input int rows, input int lat);
        return (period / rows) - ((lat + rows - 1) / rows);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer
    import refresh_sched_pkg::*;
#(
    parameter int SPREAD_LIM = 49,
    parameter int BURST_LIM  = 400
) (
    input  logic          clk,
    input  logic          rst,
    input  refresh_mode_e mode,
    output logic          tick
);
    localparam int CNT_W = $clog2(max_int(SPREAD_LIM, BURST_LIM) + 1);
    localparam logic [CNT_W-1:0] SPREAD_TC = CNT_W'(SPREAD_LIM - 1);
    localparam logic [CNT_W-1:0] BURST_TC  = CNT_W'(BURST_LIM - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;

    always_comb begin
        term = (mode == MODE_BURST) ? BURST_TC : SPREAD_TC;
        tick = (cnt_q == term);
    end

    // reload at terminal count whatever the service state of the request
    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= BURST_TC || cnt_q <= SPREAD_TC);

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt_q == '0);

endmodule

// File: rtl/rfs_row_counter.sv
module rfs_row_counter #(
    parameter int ROWS = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     adv,
    output logic [$clog2(ROWS)-1:0]  row,
    output logic                     last
);
    localparam int ROW_W = $clog2(ROWS);
    localparam logic [ROW_W-1:0] TOP = ROW_W'(ROWS - 1);

    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] row_nx;

    generate
        if ((ROWS & (ROWS - 1)) == 0) begin : g_pow2
            always_comb row_nx = row_q + 1'b1;
        end else begin : g_mod
            always_comb row_nx = (row_q == TOP) ? '0 : row_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) row_q <= '0;
        else if (adv)   row_q <= row_nx;
    end

    assign row  = row_q;
    assign last = (row_q == TOP);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> row_q == '0);

endmodule

// File: rtl/rfs_req_ctrl.sv
module rfs_req_ctrl
    import refresh_sched_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  refresh_mode_e mode_in,
    input  logic          tick,
    input  logic          strobe,
    input  logic          row_last,
    output refresh_mode_e mode_q,
    output logic          req,
    output logic          clr,
    output logic          adv,
    output logic          done
);
    logic req_q, active_q, done_q;

    assign adv  = strobe && req_q;
    assign clr  = tick && !active_q && (mode_in == MODE_BURST);
    assign req  = req_q;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= mode_in;
            req_q    <= 1'b0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (active_q) begin
                // burst runs to completion; boundaries and mode are ignored
                if (adv && row_last) begin
                    req_q    <= 1'b0;
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end else if (tick) begin
                mode_q <= mode_in;
                req_q  <= 1'b1;
                if (mode_in == MODE_BURST) active_q <= 1'b1;
            end else if (adv) begin
                req_q <= 1'b0;
            end
        end
    end

    p_spread_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SPREAD) && req_q && strobe && !tick |=> !req_q);

    p_burst_hold_r7: assert property (@(posedge clk) disable iff (rst)
        active_q && !(strobe && row_last) |=> req_q);

    p_mode_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mode_q));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int CLK_KHZ   = 25000,
    parameter int PERIOD_US = 4000,
    parameter int ROWS      = 256,
    parameter int LAT_CLKS  = 5,
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             burst_mode_i,
    input  logic             row_strobe_i,
    output logic             refresh_req_o,
    output logic [ROW_W-1:0] refresh_row_o,
    output logic             burst_done_o
);
    localparam int PERIOD_CLKS = period_clocks(CLK_KHZ, PERIOD_US);
    localparam int SLOT_CLKS   = spread_slot(PERIOD_CLKS, ROWS, LAT_CLKS);

    refresh_mode_e mode_in, mode_q;
    logic tick, clr, adv, row_last;

    assign mode_in = burst_mode_i ? MODE_BURST : MODE_SPREAD;

    rfs_interval_timer #(
        .SPREAD_LIM (SLOT_CLKS),
        .BURST_LIM  (PERIOD_CLKS)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_q),
        .tick (tick)
    );

    rfs_req_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (mode_in),
        .tick     (tick),
        .strobe   (row_strobe_i),
        .row_last (row_last),
        .mode_q   (mode_q),
        .req      (refresh_req_o),
        .clr      (clr),
        .adv      (adv),
        .done     (burst_done_o)
    );

    rfs_row_counter #(
        .ROWS (ROWS)
    ) u_rows (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .adv  (adv),
        .row  (refresh_row_o),
        .last (row_last)
    );

    p_strobe_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        !refresh_req_o && !tick |=> $stable(refresh_row_o));

    p_done_no_req_r7: assert property (@(posedge clk) disable iff (rst)
        burst_done_o |-> !refresh_req_o && refresh_row_o == '0);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        burst_done_o |=> !burst_done_o);

    p_burst_start_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> refresh_req_o && refresh_row_o == '0);

endmodule

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
    localparam int ROWS   = 8;
    localparam int PERIOD = 400;           // 100 kHz equivalent * 4000 us / 1000
    localparam int SLOT   = PERIOD / ROWS - (5 + ROWS - 1) / ROWS;   // 49
    localparam int NV     = 6;
    localparam int DELAYS [NV] = '{0, 3, 4, 1, 2, 30};

    logic clk = 1'b0, rst = 1'b1, mode = 1'b0, strobe = 1'b0;
    logic req, done;
    logic [2:0] row;
    int cyc, n_chk = 0, n_bad = 0, rise, bstart;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    refresh_sched #(.CLK_KHZ(100), .PERIOD_US(4000), .ROWS(ROWS), .LAT_CLKS(5)) u0 (
        .clk(clk), .rst(rst), .burst_mode_i(mode), .row_strobe_i(strobe),
        .refresh_req_o(req), .refresh_row_o(row), .burst_done_o(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_req(output int c);
        while (!req) @(negedge clk);
        c = cyc;
    endtask

    task automatic pulse;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req == 0 && done == 0, "R1 reset req/done", {req, done}, 0);
        check(row == 0, "R1 reset row", row, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req == 0 && row == 0, "R1 after release", {req, row}, 0);

        // R4: unrequested strobe
        repeat (5) @(negedge clk);
        pulse();
        check(row == 0, "R4 stray strobe row", row, 0);
        check(req == 0, "R4 stray strobe req", req, 0);

        // spread mode table: service delay per refresh
        for (int i = 0; i < NV; i++) begin
            wait_req(rise);
            check(rise == SLOT * (i + 1), "R2/R5 rise time", rise, SLOT * (i + 1));
            repeat (DELAYS[i]) @(negedge clk);
            check(req == 1, "R3 held until strobe", req, 1);
            pulse();
            check(req == 0, "R3 drop after strobe", req, 0);
            check(row == 3'(i + 1), "R3 row advance", row, i + 1);
        end

        // burst: row is 6 before the boundary
        mode = 1'b1;
        wait_req(bstart);
        check(bstart == SLOT * (NV + 1), "R6 burst at boundary", bstart, SLOT * (NV + 1));
        check(row == 0, "R6 row cleared", row, 0);
        mode = 1'b0;                     // R9: change during burst
        strobe = 1'b1;
        for (int j = 0; j < ROWS; j++) begin
            @(negedge clk);
            if (j == ROWS - 1) strobe = 1'b0;
            if (j < ROWS - 1) begin
                check(req == 1, "R7/R9 burst held", req, 1);
                check(row == 3'(j + 1), "R7 burst row", row, j + 1);
                check(done == 0, "R7 done early", done, 0);
            end else begin
                check(req == 0, "R7 burst end req", req, 0);
                check(row == 0, "R7 wrap row", row, 0);
                check(done == 1, "R7 done pulse", done, 1);
            end
        end
        @(negedge clk);
        check(done == 0, "R7 done one cycle", done, 0);

        wait_req(rise);
        check(rise == bstart + PERIOD, "R8/R9 quiet rest of period", rise, bstart + PERIOD);
        pulse();
        check(row == 1, "R9 spread refresh after burst", row, 1);
        wait_req(rise);
        check(rise == bstart + PERIOD + SLOT, "R9 spread slot adopted", rise, bstart + PERIOD + SLOT);
        check(done == 0, "R7 no stray done", done, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule